// File: doc/BRIEF.md
# Write-Queue Hazard Lock with Forwarding

This unit resolves read-after-write and write-after-write hazards for a small register file in an in-order pipeline. Pending writes sit in a circular queue. Each queue entry holds a target address, a data value and a valid flag. Writes reach the internal register array only when they are released, one per release and oldest first. A younger read that targets a pending address is served from the queue entry instead of the stale array value.

Every write passes through three steps. A reservation claims a queue slot and returns the slot index. The write itself fills that slot's data. The release commits the oldest slot. Reads run through a small set of tracking slots selected by an identifier. A read reservation records which queue entry it depends on, or takes a snapshot of the array when there is no dependency. A read block reports whether the value is ready yet. The read returns the value, and a read release frees the slot. Reserving a write needs no separate block step, because a write never has to wait once its slot exists.

For speculation, the current tail pointer serves as a checkpoint. A rollback to an earlier checkpoint discards every write reserved after it.

Top module: `wq_hazard_lock`

## Requirements
- R1: After reset the queue is empty. `resWrReady` is 1, `ckptTail` is 0, `resWrIdx` is 0, and every array location reads as 0.
- R2: An accepted write reservation (`resWrValid` and `resWrReady` both 1) places the address at the tail slot. `resWrIdx` shows that slot index beforehand. The index then advances by one modulo DEPTH, and `ckptTail` (which carries one extra wrap bit) advances by one.
- R3: Each `relWrValid` pulse commits the oldest pending entry to the array and frees it. When two writes target one address, the later-reserved value is what remains.
- R4: A read reservation for an address with pending writes depends on the most recently reserved matching entry. With no match, it snapshots the array value in that same cycle.
- R5: `blkRdGo` for slot `blkRdId` is 0 while the slot's recorded entry has not been written, and 1 when the slot has no dependency.
- R6: A write performed in a cycle is visible in that same cycle on `blkRdGo` and on `rdData` for a read slot that depends on that entry.
- R7: After `relRdValid` for a slot, and with no new reservation on that slot, `blkRdGo` for that slot is 1.
- R8: When DEPTH writes are pending, `resWrReady` is 0. A write reservation in that state is ignored and `resWrIdx` does not move.
- R9: A rollback (`rbValid` with `rbTail`) sets `ckptTail` to `rbTail` and discards the newer entries. A later read of their addresses finds no dependency, and the next reservation reuses the slot at `rbTail`. `resWrReady` is 0 during a rollback.
- R10: A read reserved in the same cycle as the release of the only matching write receives that write's data and does not stall.
- R11: A read that depends on an entry still returns that entry's data after the entry has been committed and freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| resWrValid | input | 1 | Reserve a write slot |
| resWrAddr | input | ADDR_W | Address of the reserved write |
| resWrReady | output | 1 | Queue can accept a write reservation |
| resWrIdx | output | log2(DEPTH) | Slot index the next reservation receives |
| wrValid | input | 1 | Perform a reserved write |
| wrIdx | input | log2(DEPTH) | Slot index being written |
| wrData | input | DATA_W | Write data |
| relWrValid | input | 1 | Release (commit) the oldest write |
| resRdValid | input | 1 | Reserve a read tracking slot |
| resRdId | input | RID_W | Read slot being reserved |
| resRdAddr | input | ADDR_W | Address of the reserved read |
| blkRdId | input | RID_W | Read slot queried for readiness |
| blkRdGo | output | 1 | Queried read may proceed |
| rdId | input | RID_W | Read slot whose value is returned |
| rdData | output | DATA_W | Read value (forwarded or snapshot) |
| relRdValid | input | 1 | Release a read tracking slot |
| relRdId | input | RID_W | Read slot being released |
| ckptTail | output | log2(DEPTH)+1 | Current tail pointer, usable as checkpoint |
| rbValid | input | 1 | Roll back to a checkpoint |
| rbTail | input | log2(DEPTH)+1 | Checkpoint to restore |

## Verification
The bound checker checks the tail pointer on every cycle. It advances by exactly one on an accepted reservation, holds while the queue is full or idle, and takes the checkpoint value on a rollback. It also checks that a released read slot reports ready. The bench scenarios are what show the data behaviour. They cover youngest-match selection among duplicate addresses, same-cycle bypass of a write into a waiting read, oldest-first commit order seen through later reads, forwarding across the commit of the depended-on entry, and the same-cycle release-and-reserve corner. They also show that rolled-back entries no longer forward.

// File: rtl/wql_pkg.sv
package wql_pkg;
  // Strobes from the pointer control to the queue datapath.
  typedef struct packed {
    logic push;    // accepted write reservation at tail
    logic pop;     // commit of the head entry
    logic rewind;  // rollback this cycle
  } wqlStrobe_t;
endpackage

// File: rtl/wql_ctrl.sv
module wql_ctrl #(
  parameter int DEPTH = 4,
  parameter int IDX_W = 2,
  parameter int PTR_W = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  resWrValid,
  input  logic                  relWrValid,
  input  logic                  rbValid,
  input  logic [PTR_W-1:0]      rbTail,
  output wql_pkg::wqlStrobe_t   strobe,
  output logic [IDX_W-1:0]      headIdx,
  output logic [IDX_W-1:0]      tailIdx,
  output logic [DEPTH-1:0]      liveMask,
  output logic [DEPTH-1:0]      killMask,
  output logic                  resWrReady,
  output logic [PTR_W-1:0]      ckptTail
);
  logic [PTR_W-1:0] headPtr, tailPtr;
  logic [PTR_W-1:0] count, rbCount;
  logic             full;

  assign count      = tailPtr - headPtr;
  assign rbCount    = rbTail - headPtr;
  assign full       = (count == PTR_W'(DEPTH));
  assign resWrReady = !full && !rbValid;
  assign headIdx    = headPtr[IDX_W-1:0];
  assign tailIdx    = tailPtr[IDX_W-1:0];
  assign ckptTail   = tailPtr;

  assign strobe.push   = resWrValid && resWrReady;
  assign strobe.pop    = relWrValid && (count != '0);
  assign strobe.rewind = rbValid;

  // Age of each slot relative to head decides occupancy and rollback kill.
  always_comb begin
    logic [IDX_W-1:0] age;
    for (int i = 0; i < DEPTH; i++) begin
      age = IDX_W'(i) - headIdx;
      liveMask[i] = ({1'b0, age} < count);
      killMask[i] = ({1'b0, age} >= rbCount) && ({1'b0, age} < count);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      headPtr <= headPtr + PTR_W'(strobe.pop);
      if (strobe.rewind) tailPtr <= rbTail;
      else               tailPtr <= tailPtr + PTR_W'(strobe.push);
    end
  end
endmodule

// File: rtl/wql_datapath.sv
module wql_datapath #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int NRD    = 2,
  parameter int IDX_W  = 2,
  parameter int RID_W  = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  wql_pkg::wqlStrobe_t strobe,
  input  logic [IDX_W-1:0]    headIdx,
  input  logic [IDX_W-1:0]    tailIdx,
  input  logic [DEPTH-1:0]    liveMask,
  input  logic [DEPTH-1:0]    killMask,
  input  logic [ADDR_W-1:0]   resWrAddr,
  input  logic                wrValid,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                resRdValid,
  input  logic [RID_W-1:0]    resRdId,
  input  logic [ADDR_W-1:0]   resRdAddr,
  input  logic [RID_W-1:0]    blkRdId,
  input  logic [RID_W-1:0]    rdId,
  input  logic                relRdValid,
  input  logic [RID_W-1:0]    relRdId,
  output logic                blkRdGo,
  output logic [DATA_W-1:0]   rdData
);
  localparam int NSTORE = 1 << ADDR_W;

  logic [ADDR_W-1:0] qAddr  [DEPTH];
  logic [DATA_W-1:0] qData  [DEPTH];
  logic [DEPTH-1:0]  qValid;
  logic [DATA_W-1:0] store  [NSTORE];

  logic              trDep  [NRD];
  logic [IDX_W-1:0]  trIdx  [NRD];
  logic [DATA_W-1:0] trSnap [NRD];

  // Youngest-match search over occupied slots, scanned oldest to youngest.
  logic             hit, hitHead, headOnly;
  logic [IDX_W-1:0] hitIdx;
  always_comb begin
    logic [IDX_W-1:0] idx;
    hit     = 1'b0;
    hitHead = 1'b0;
    hitIdx  = headIdx;
    for (int k = 0; k < DEPTH; k++) begin
      idx = headIdx + IDX_W'(k);
      if (liveMask[idx] && (qAddr[idx] == resRdAddr)) begin
        hit     = 1'b1;
        hitIdx  = idx;
        hitHead = (k == 0);
      end
    end
    headOnly = hit && hitHead && strobe.pop;
  end

  // Same-cycle bypass from the write port into readiness and data.
  logic [IDX_W-1:0] blkEntry, rdEntry;
  assign blkEntry = trIdx[blkRdId];
  assign rdEntry  = trIdx[rdId];
  assign blkRdGo  = !trDep[blkRdId] || qValid[blkEntry] ||
                    (wrValid && (wrIdx == blkEntry));
  always_comb begin
    if (!trDep[rdId])                         rdData = trSnap[rdId];
    else if (wrValid && (wrIdx == rdEntry))   rdData = wrData;
    else                                      rdData = qData[rdEntry];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qValid <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        qAddr[i] <= '0;
        qData[i] <= '0;
      end
      for (int a = 0; a < NSTORE; a++) store[a] <= '0;
      for (int t = 0; t < NRD; t++) begin
        trDep[t]  <= 1'b0;
        trIdx[t]  <= '0;
        trSnap[t] <= '0;
      end
    end else begin
      // queue entries
      if (wrValid) begin
        qData[wrIdx]  <= wrData;
        qValid[wrIdx] <= 1'b1;
      end
      if (strobe.pop) begin
        store[qAddr[headIdx]] <= qData[headIdx];
        qValid[headIdx]       <= 1'b0;
      end
      if (strobe.rewind) begin
        for (int i = 0; i < DEPTH; i++)
          if (killMask[i]) qValid[i] <= 1'b0;
      end
      if (strobe.push) begin
        qAddr[tailIdx]  <= resWrAddr;
        qValid[tailIdx] <= 1'b0;
      end
      // read trackers: snapshot on commit of dependency, then release, then reserve
      for (int t = 0; t < NRD; t++) begin
        if (strobe.pop && trDep[t] && (trIdx[t] == headIdx)) begin
          trSnap[t] <= qData[headIdx];
          trDep[t]  <= 1'b0;
        end
      end
      if (relRdValid) trDep[relRdId] <= 1'b0;
      if (resRdValid) begin
        if (hit && !headOnly) begin
          trDep[resRdId] <= 1'b1;
          trIdx[resRdId] <= hitIdx;
        end else begin
          trDep[resRdId]  <= 1'b0;
          trSnap[resRdId] <= headOnly ? qData[headIdx] : store[resRdAddr];
        end
      end
    end
  end
endmodule

// File: rtl/wq_hazard_lock.sv
module wq_hazard_lock #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int NRD    = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1,
  localparam int RID_W = (NRD > 1) ? $clog2(NRD) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resWrValid,
  input  logic [ADDR_W-1:0] resWrAddr,
  output logic              resWrReady,
  output logic [IDX_W-1:0]  resWrIdx,
  input  logic              wrValid,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              relWrValid,
  input  logic              resRdValid,
  input  logic [RID_W-1:0]  resRdId,
  input  logic [ADDR_W-1:0] resRdAddr,
  input  logic [RID_W-1:0]  blkRdId,
  output logic              blkRdGo,
  input  logic [RID_W-1:0]  rdId,
  output logic [DATA_W-1:0] rdData,
  input  logic              relRdValid,
  input  logic [RID_W-1:0]  relRdId,
  output logic [PTR_W-1:0]  ckptTail,
  input  logic              rbValid,
  input  logic [PTR_W-1:0]  rbTail
);
  wql_pkg::wqlStrobe_t strobe;
  logic [IDX_W-1:0] headIdx, tailIdx;
  logic [DEPTH-1:0] liveMask, killMask;

  assign resWrIdx = tailIdx;

  wql_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PTR_W(PTR_W)) ctrl (
    .clk(clk), .rstN(rstN), .resWrValid(resWrValid), .relWrValid(relWrValid),
    .rbValid(rbValid), .rbTail(rbTail), .strobe(strobe), .headIdx(headIdx),
    .tailIdx(tailIdx), .liveMask(liveMask), .killMask(killMask),
    .resWrReady(resWrReady), .ckptTail(ckptTail)
  );

  wql_datapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NRD(NRD),
                 .IDX_W(IDX_W), .RID_W(RID_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .headIdx(headIdx), .tailIdx(tailIdx),
    .liveMask(liveMask), .killMask(killMask), .resWrAddr(resWrAddr),
    .wrValid(wrValid), .wrIdx(wrIdx), .wrData(wrData), .resRdValid(resRdValid),
    .resRdId(resRdId), .resRdAddr(resRdAddr), .blkRdId(blkRdId), .rdId(rdId),
    .relRdValid(relRdValid), .relRdId(relRdId), .blkRdGo(blkRdGo), .rdData(rdData)
  );
endmodule

// File: rtl/wq_hazard_lock_chk.sv
module wq_hazard_lock_chk #(
  parameter int PTR_W = 3,
  parameter int RID_W = 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             resWrValid,
  input logic             resWrReady,
  input logic [PTR_W-1:0] ckptTail,
  input logic             rbValid,
  input logic [PTR_W-1:0] rbTail,
  input logic             resRdValid,
  input logic [RID_W-1:0] resRdId,
  input logic [RID_W-1:0] blkRdId,
  input logic             blkRdGo,
  input logic             relRdValid,
  input logic [RID_W-1:0] relRdId
);
  // R2: accepted reservation moves the tail by one
  a_r2_tail_step: assert property (@(posedge clk) disable iff (!rstN)
    (resWrValid && resWrReady) |=> ckptTail == PTR_W'($past(ckptTail) + 1'b1));

  // R8: refused or absent reservation leaves the tail in place
  a_r8_tail_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!(resWrValid && resWrReady) && !rbValid) |=> $stable(ckptTail));

  // R9: rollback restores the given checkpoint
  a_r9_rollback_tail: assert property (@(posedge clk) disable iff (!rstN)
    rbValid |=> ckptTail == $past(rbTail));

  // R9: no reservation accepted during rollback
  a_r9_no_push_on_rollback: assert property (@(posedge clk) disable iff (!rstN)
    rbValid |-> !resWrReady);

  // R7: a released read slot reports ready
  a_r7_release_frees: assert property (@(posedge clk) disable iff (!rstN)
    (relRdValid && !(resRdValid && resRdId == relRdId))
      |=> (blkRdId != $past(relRdId)) || blkRdGo);
endmodule

bind wq_hazard_lock wq_hazard_lock_chk #(.PTR_W(PTR_W), .RID_W(RID_W)) chk (
  .clk(clk), .rstN(rstN), .resWrValid(resWrValid), .resWrReady(resWrReady),
  .ckptTail(ckptTail), .rbValid(rbValid), .rbTail(rbTail),
  .resRdValid(resRdValid), .resRdId(resRdId), .blkRdId(blkRdId),
  .blkRdGo(blkRdGo), .relRdValid(relRdValid), .relRdId(relRdId)
);

// File: tb/wq_hazard_lock_test.sv
module wq_hazard_lock_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        resWrValid;
  logic [3:0]  resWrAddr;
  logic        resWrReady;
  logic [1:0]  resWrIdx;
  logic        wrValid;
  logic [1:0]  wrIdx;
  logic [15:0] wrData;
  logic        relWrValid;
  logic        resRdValid;
  logic [0:0]  resRdId;
  logic [3:0]  resRdAddr;
  logic [0:0]  blkRdId;
  logic        blkRdGo;
  logic [0:0]  rdId;
  logic [15:0] rdData;
  logic        relRdValid;
  logic [0:0]  relRdId;
  logic [2:0]  ckptTail;
  logic        rbValid;
  logic [2:0]  rbTail;

  wq_hazard_lock uut (
    .clk(clk), .rstN(rstN), .resWrValid(resWrValid), .resWrAddr(resWrAddr),
    .resWrReady(resWrReady), .resWrIdx(resWrIdx), .wrValid(wrValid), .wrIdx(wrIdx),
    .wrData(wrData), .relWrValid(relWrValid), .resRdValid(resRdValid),
    .resRdId(resRdId), .resRdAddr(resRdAddr), .blkRdId(blkRdId), .blkRdGo(blkRdGo),
    .rdId(rdId), .rdData(rdData), .relRdValid(relRdValid), .relRdId(relRdId),
    .ckptTail(ckptTail), .rbValid(rbValid), .rbTail(rbTail)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  logic [2:0]  expPtr = '0;
  logic        monRd;
  logic [15:0] expData[$];
  string       expReq[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clearIns();
    resWrValid = 0; resWrAddr = '0; wrValid = 0; wrIdx = '0; wrData = '0;
    relWrValid = 0; resRdValid = 0; resRdId = '0; resRdAddr = '0;
    blkRdId = '0; rdId = '0; relRdValid = 0; relRdId = '0;
    rbValid = 0; rbTail = '0; monRd = 0;
  endtask

  task automatic nextCyc();
    @(posedge clk); #1; clearIns();
  endtask

  // driver side of the scoreboard
  task automatic expectRead(logic [0:0] id, logic [15:0] data, string req);
    rdId = id; monRd = 1;
    expData.push_back(data);
    expReq.push_back(req);
  endtask

  task automatic reserveWr(logic [3:0] addr, output logic [1:0] slot);
    resWrValid = 1; resWrAddr = addr;
    @(negedge clk);
    chk("R2 slot index", resWrIdx, expPtr[1:0]);
    slot = expPtr[1:0];
    expPtr = expPtr + 1;
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (monRd) begin
      logic [15:0] e;
      string r;
      e = expData.pop_front();
      r = expReq.pop_front();
      chk(r, rdData, e);
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [1:0] e0, e1, e2, eG, eR;
    logic [1:0] eF[4];
    logic [2:0] ckpt;
    clearIns();
    rstN = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    chk("R1 ready", resWrReady, 1);
    chk("R1 ckpt", ckptTail, 0);
    chk("R1 idx", resWrIdx, 0);

    // R1 array is zero, no dependency
    nextCyc(); resRdValid = 1; resRdId = 0; resRdAddr = 3;
    nextCyc(); blkRdId = 0; expectRead(0, 16'h0, "R1 array zero");
    relRdValid = 1; relRdId = 0;
    @(negedge clk); chk("R5 no conflict go", blkRdGo, 1);

    // dependency, stall, same-cycle bypass, commit
    nextCyc(); reserveWr(4'd5, e0);
    nextCyc(); resRdValid = 1; resRdId = 0; resRdAddr = 5;
    nextCyc(); blkRdId = 0;
    @(negedge clk); chk("R5 stall on pending", blkRdGo, 0);
    nextCyc(); wrValid = 1; wrIdx = e0; wrData = 16'h1111; blkRdId = 0;
    expectRead(0, 16'h1111, "R6 bypass data");
    @(negedge clk); chk("R6 bypass go", blkRdGo, 1);
    nextCyc(); relWrValid = 1; expectRead(0, 16'h1111, "R4 forwarded");
    nextCyc(); expectRead(0, 16'h1111, "R11 after commit"); relRdValid = 1; relRdId = 0;
    nextCyc(); resRdValid = 1; resRdId = 1; resRdAddr = 5;
    nextCyc(); blkRdId = 1; expectRead(1, 16'h1111, "R3 committed");
    relRdValid = 1; relRdId = 1;

    // youngest match among duplicates, commit order
    nextCyc(); reserveWr(4'd7, e1);
    nextCyc(); wrValid = 1; wrIdx = e1; wrData = 16'hAAAA; reserveWr(4'd7, e2);
    nextCyc(); resRdValid = 1; resRdId = 1; resRdAddr = 7;
    nextCyc(); blkRdId = 1;
    @(negedge clk); chk("R4 youngest match stalls", blkRdGo, 0);
    nextCyc(); wrValid = 1; wrIdx = e2; wrData = 16'hBBBB;
    expectRead(1, 16'hBBBB, "R4 youngest data");
    nextCyc(); relWrValid = 1;
    nextCyc(); relWrValid = 1;
    nextCyc(); relRdValid = 1; relRdId = 1; resRdValid = 1; resRdId = 0; resRdAddr = 7;
    nextCyc(); expectRead(0, 16'hBBBB, "R3 later write wins"); relRdValid = 1; relRdId = 0;

    // full queue
    for (int i = 0; i < 4; i++) begin
      nextCyc(); reserveWr(4'(i + 1), eF[i]);
    end
    nextCyc(); resWrValid = 1; resWrAddr = 9;
    @(negedge clk); chk("R8 ready low when full", resWrReady, 0);
    nextCyc();
    @(negedge clk); chk("R8 idx unchanged", resWrIdx, expPtr[1:0]);
    for (int i = 0; i < 4; i++) begin
      nextCyc(); wrValid = 1; wrIdx = eF[i]; wrData = 16'h0100 + 16'(i);
    end
    for (int i = 0; i < 4; i++) begin
      nextCyc(); relWrValid = 1;
    end
    nextCyc(); resRdValid = 1; resRdId = 0; resRdAddr = 3;
    @(negedge clk); chk("R8 ready after drain", resWrReady, 1);
    nextCyc(); expectRead(0, 16'h0102, "R3 drained value"); relRdValid = 1; relRdId = 0;

    // same-cycle release and read reservation
    nextCyc(); reserveWr(4'd9, eG);
    nextCyc(); wrValid = 1; wrIdx = eG; wrData = 16'hC0DE;
    nextCyc(); relWrValid = 1; resRdValid = 1; resRdId = 1; resRdAddr = 9;
    nextCyc(); blkRdId = 1; expectRead(1, 16'hC0DE, "R10 data");
    relRdValid = 1; relRdId = 1;
    @(negedge clk); chk("R10 no stall", blkRdGo, 1);

    // checkpoint and rollback
    nextCyc();
    @(negedge clk); chk("R9 ckpt value", ckptTail, expPtr);
    ckpt = ckptTail;
    nextCyc(); reserveWr(4'd10, eR);
    nextCyc(); wrValid = 1; wrIdx = eR; wrData = 16'hDEAD; reserveWr(4'd11, e0);
    nextCyc(); rbValid = 1; rbTail = ckpt;
    expPtr = ckpt;
    nextCyc(); resRdValid = 1; resRdId = 0; resRdAddr = 10;
    @(negedge clk); chk("R9 tail restored", ckptTail, ckpt);
    nextCyc(); blkRdId = 0; expectRead(0, 16'h0, "R9 discarded not forwarded");
    relRdValid = 1; relRdId = 0;
    @(negedge clk); chk("R9 no dependency", blkRdGo, 1);
    nextCyc(); reserveWr(4'd12, e1);
    chk("R9 slot reused", e1, ckpt[1:0]);
    nextCyc(); wrValid = 1; wrIdx = e1; wrData = 16'h1234;
    nextCyc(); relWrValid = 1;

    // read release frees tracking
    nextCyc(); reserveWr(4'd13, e2);
    nextCyc(); resRdValid = 1; resRdId = 1; resRdAddr = 13;
    nextCyc(); blkRdId = 1; relRdValid = 1; relRdId = 1;
    @(negedge clk); chk("R7 stall before release", blkRdGo, 0);
    nextCyc(); blkRdId = 1;
    @(negedge clk); chk("R7 free after release", blkRdGo, 1);
    nextCyc(); wrValid = 1; wrIdx = e2; wrData = 16'h5555;
    nextCyc(); relWrValid = 1;
    nextCyc(); resRdValid = 1; resRdId = 0; resRdAddr = 12;
    nextCyc(); expectRead(0, 16'h1234, "R3 after rollback commit");
    nextCyc();
    repeat (2) @(posedge clk);
    finishRun();
  end
endmodule